// File: doc/BRIEF.md
# Single-Bus Accumulator Microcomputer Core

This block is a complete stored-program machine with an 8-bit data path and 4-bit addresses. Its program counter, memory address register, a 16-word program/data ROM, an instruction register, accumulator, second operand register, add/subtract ALU and output register all exchange values over a single shared 8-bit bus. Addresses and data travel over that same bus. Each source puts a value on the bus only while its own enable strobe is raised.

A beat controller runs every instruction in six clock beats. The first three beats fetch the instruction and advance the program counter. The last three beats carry out the operation that the upper four bits of the instruction select. The lower four bits give the operand address or the jump target. The ROM contents are a parameter, so each instance carries its own program.

The output register value and the program counter are brought out so that an external display can show them. A synchronous clear lets the output register be wiped between debug runs without resetting the machine.

Top module: `acc_micro_core`

## Requirements
- R1: The program counter resets to 0 and adds one, modulo 16, once per instruction in the third beat. `cur_addr` always shows the program counter.
- R2: At most one bus source (program counter, ROM, instruction operand, accumulator, ALU) is enabled in any beat. Values move between registers only over the bus.
- R3: Beats run in a fixed cycle. Beat 1 loads the address register from the program counter, beat 2 loads the instruction register from the ROM word at that address, and beat 3 increments the program counter. After beat 6 the cycle returns to beat 1.
- R4: Opcode 0000 (load) copies the ROM word at the operand address into the accumulator. The operand address is sent to the address register in beat 4 and the word is loaded in beat 5.
- R5: For opcode 0001 (add) and opcode 0010 (subtract), beat 5 loads the operand register from the ROM word at the operand address. Beat 6 then replaces the accumulator with the sum or difference, wrapped modulo 256, with no flags.
- R6: Opcode 1110 (output) copies the accumulator into the output register in beat 4. A high `out_clr` clears the output register at the next clock edge and takes priority over a load in the same edge.
- R7: Opcode 1111 (halt) stops the controller after beat 4. From then on the program counter and the output register hold their values, apart from `out_clr`, until reset.
- R8: Opcode 0011 (jump) loads the program counter from the operand field in beat 4, so the next fetch comes from that address.
- R9: Any other opcode changes no register other than the fetch path (address register, instruction register, program counter). It still takes six beats.
- R10: A low `rst_n` asynchronously returns the controller to beat 1 and clears the program counter, all data registers and the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_clr | input | 1 | Synchronous clear of the output register |
| out_value | output | 8 | Current content of the output register |
| cur_addr | output | 4 | Current program counter value |

## Verification
The hardest situation to reach from the ports is an output load and `out_clr` landing on the same clock edge. The only way to trigger an output load is to run a program up to the beat-4 edge of an output instruction. The bench therefore restarts a known program from reset, counts edges up to the one just before that beat, and raises the clear for exactly that edge. It also runs several instances in parallel with different ROM images, covering both wrap directions, an undefined opcode and a forward jump. Each program's last result is therefore only reachable through the path being tested.

// File: rtl/acc_pkg.sv
package acc_pkg;

   localparam int OPC_W = 4;
   localparam int SEL_W = 4;

   // bus source indices, in the order the enable vector is built
   localparam int SRC_PC  = 0;
   localparam int SRC_ROM = 1;
   localparam int SRC_IR  = 2;
   localparam int SRC_ACC = 3;
   localparam int SRC_ALU = 4;
   localparam int N_SRC   = 5;

   typedef enum logic [2:0] {
      BT_1    = 3'd0,
      BT_2    = 3'd1,
      BT_3    = 3'd2,
      BT_4    = 3'd3,
      BT_5    = 3'd4,
      BT_6    = 3'd5,
      BT_HALT = 3'd6
   } beat_e;

   localparam logic [OPC_W-1:0] OP_LDA = 4'h0;
   localparam logic [OPC_W-1:0] OP_ADD = 4'h1;
   localparam logic [OPC_W-1:0] OP_SUB = 4'h2;
   localparam logic [OPC_W-1:0] OP_JMP = 4'h3;
   localparam logic [OPC_W-1:0] OP_OUT = 4'hE;
   localparam logic [OPC_W-1:0] OP_HLT = 4'hF;

   localparam logic [SEL_W-1:0] SEL_PASS = 4'h0;
   localparam logic [SEL_W-1:0] SEL_ADD  = 4'h1;
   localparam logic [SEL_W-1:0] SEL_SUB  = 4'h2;

   typedef struct packed {
      logic             drv_pc;
      logic             drv_rom;
      logic             drv_opnd;
      logic             drv_acc;
      logic             drv_alu;
      logic             ld_mar;
      logic             ld_ir;
      logic             ld_acc;
      logic             ld_opb;
      logic             ld_out;
      logic             ld_pc;
      logic             pc_step;
      logic [SEL_W-1:0] alu_sel;
   } ctrl_word_t;

endpackage

// File: rtl/acc_pc.sv
module acc_pc #(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   output logic [ADDR_W-1:0] count
);

   if (ADDR_W < 1) begin : g_bad_w
      $error("acc_pc: ADDR_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (load)
         count <= load_val;
      else if (step)
         count <= count + 1'b1;
   end

endmodule

// File: rtl/acc_rom.sv
module acc_rom #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4,
   localparam int DEPTH = 1 << ADDR_W,
   parameter logic [DATA_W-1:0] IMAGE [DEPTH] = '{default: '0}
) (
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   assign rd_data = IMAGE[rd_addr];

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int STYLE  = 0   // 0: separate add and subtract, 1: one shared adder
) (
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [SEL_W-1:0]  sel,
   output logic [DATA_W-1:0] res
);

   if (STYLE == 0) begin : g_split
      always_comb begin
         unique case (sel)
            SEL_ADD: res = opa + opb;
            SEL_SUB: res = opa - opb;
            default: res = opa;
         endcase
      end
   end else begin : g_shared
      logic                 inv;
      logic [DATA_W-1:0]    opb_x;
      logic [DATA_W-1:0]    sum;
      assign inv   = (sel == SEL_SUB);
      assign opb_x = opb ^ {DATA_W{inv}};
      assign sum   = opa + opb_x + {{(DATA_W-1){1'b0}}, inv};
      assign res   = (sel == SEL_ADD || sel == SEL_SUB) ? sum : opa;
   end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
   import acc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPC_W-1:0] opcode,
   output beat_e            beat,
   output ctrl_word_t       cw,
   output logic             halted
);

   beat_e beat_nx;

   always_comb begin
      unique case (beat)
         BT_1:    beat_nx = BT_2;
         BT_2:    beat_nx = BT_3;
         BT_3:    beat_nx = BT_4;
         BT_4:    beat_nx = (opcode == OP_HLT) ? BT_HALT : BT_5;
         BT_5:    beat_nx = BT_6;
         BT_6:    beat_nx = BT_1;
         BT_HALT: beat_nx = BT_HALT;
         default: beat_nx = BT_1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         beat <= BT_1;
      else
         beat <= beat_nx;
   end

   always_comb begin
      cw = '0;
      cw.alu_sel = SEL_PASS;
      unique case (beat)
         BT_1: begin
            cw.drv_pc = 1'b1;
            cw.ld_mar = 1'b1;
         end
         BT_2: begin
            cw.drv_rom = 1'b1;
            cw.ld_ir   = 1'b1;
         end
         BT_3: cw.pc_step = 1'b1;
         BT_4: begin
            unique case (opcode)
               OP_LDA, OP_ADD, OP_SUB: begin
                  cw.drv_opnd = 1'b1;
                  cw.ld_mar   = 1'b1;
               end
               OP_OUT: begin
                  cw.drv_acc = 1'b1;
                  cw.ld_out  = 1'b1;
               end
               OP_JMP: begin
                  cw.drv_opnd = 1'b1;
                  cw.ld_pc    = 1'b1;
               end
               default: ;
            endcase
         end
         BT_5: begin
            unique case (opcode)
               OP_LDA: begin
                  cw.drv_rom = 1'b1;
                  cw.ld_acc  = 1'b1;
               end
               OP_ADD, OP_SUB: begin
                  cw.drv_rom = 1'b1;
                  cw.ld_opb  = 1'b1;
               end
               default: ;
            endcase
         end
         BT_6: begin
            unique case (opcode)
               OP_ADD: begin
                  cw.drv_alu = 1'b1;
                  cw.ld_acc  = 1'b1;
                  cw.alu_sel = SEL_ADD;
               end
               OP_SUB: begin
                  cw.drv_alu = 1'b1;
                  cw.ld_acc  = 1'b1;
                  cw.alu_sel = SEL_SUB;
               end
               default: ;
            endcase
         end
         default: ;
      endcase
   end

   assign halted = (beat == BT_HALT);

endmodule

// File: rtl/acc_micro_core.sv
module acc_micro_core
   import acc_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 4,
   parameter int ALU_STYLE = 0,
   parameter logic [DATA_W-1:0] ROM_IMAGE [1 << ADDR_W] = '{
      8'h09, 8'h1A, 8'h2B, 8'hE0, 8'hF0, 8'h00, 8'h00, 8'h00,
      8'h00, 8'h05, 8'h07, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h00}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              out_clr,
   output logic [DATA_W-1:0] out_value,
   output logic [ADDR_W-1:0] cur_addr
);

   localparam int PAD_W = DATA_W - ADDR_W;

   if (DATA_W != OPC_W + ADDR_W) begin : g_bad_split
      $error("acc_micro_core: DATA_W must equal opcode width plus ADDR_W");
   end
   if (ALU_STYLE != 0 && ALU_STYLE != 1) begin : g_bad_alu
      $error("acc_micro_core: ALU_STYLE must be 0 or 1");
   end

   ctrl_word_t        cw;
   beat_e             beat;
   logic              halted;
   logic [DATA_W-1:0] bus;
   logic [ADDR_W-1:0] pc;
   logic [ADDR_W-1:0] mar;
   logic [DATA_W-1:0] ir;
   logic [DATA_W-1:0] acc;
   logic [DATA_W-1:0] opb;
   logic [DATA_W-1:0] out_r;
   logic [DATA_W-1:0] rom_q;
   logic [DATA_W-1:0] alu_q;
   logic [DATA_W-1:0] src [N_SRC];
   logic [N_SRC-1:0]  en;

   acc_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .opcode (ir[DATA_W-1 -: OPC_W]),
      .beat   (beat),
      .cw     (cw),
      .halted (halted)
   );

   acc_pc #(.ADDR_W(ADDR_W)) u_pc (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (cw.pc_step),
      .load     (cw.ld_pc),
      .load_val (bus[ADDR_W-1:0]),
      .count    (pc)
   );

   acc_rom #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IMAGE(ROM_IMAGE)) u_rom (
      .rd_addr (mar),
      .rd_data (rom_q)
   );

   acc_alu #(.DATA_W(DATA_W), .STYLE(ALU_STYLE)) u_alu (
      .opa (acc),
      .opb (opb),
      .sel (cw.alu_sel),
      .res (alu_q)
   );

   // bus sources and their strobes, indexed by the package source order
   assign src[SRC_PC]  = {{PAD_W{1'b0}}, pc};
   assign src[SRC_ROM] = rom_q;
   assign src[SRC_IR]  = {{PAD_W{1'b0}}, ir[ADDR_W-1:0]};
   assign src[SRC_ACC] = acc;
   assign src[SRC_ALU] = alu_q;

   assign en[SRC_PC]  = cw.drv_pc;
   assign en[SRC_ROM] = cw.drv_rom;
   assign en[SRC_IR]  = cw.drv_opnd;
   assign en[SRC_ACC] = cw.drv_acc;
   assign en[SRC_ALU] = cw.drv_alu;

   // priority-free shared bus: masked sources merged by OR
   always_comb begin
      bus = '0;
      for (int i = 0; i < N_SRC; i++)
         bus = bus | (src[i] & {DATA_W{en[i]}});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mar <= '0;
         ir  <= '0;
         acc <= '0;
         opb <= '0;
      end else begin
         if (cw.ld_mar) mar <= bus[ADDR_W-1:0];
         if (cw.ld_ir)  ir  <= bus;
         if (cw.ld_acc) acc <= bus;
         if (cw.ld_opb) opb <= bus;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         out_r <= '0;
      else if (out_clr)
         out_r <= '0;
      else if (cw.ld_out)
         out_r <= bus;
   end

   assign out_value = out_r;
   assign cur_addr  = pc;

endmodule

// File: rtl/acc_micro_core_chk.sv
module acc_micro_core_chk
   import acc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              out_clr,
   input beat_e             beat,
   input logic [N_SRC-1:0]  en,
   input logic [ADDR_W-1:0] pc,
   input logic [ADDR_W-1:0] mar,
   input logic              halted,
   input logic [DATA_W-1:0] out_value
);

   p_bus_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(en));

   p_mar_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      beat == BT_1 |=> mar == $past(pc));

   p_beat_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      beat == BT_6 |=> beat == BT_1);

   p_pc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      beat == BT_3 |=> pc == ADDR_W'($past(pc) + 1'b1));

   p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_clr |=> out_value == '0);

   p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted && $stable(pc));

   p_halt_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
      halted && !out_clr |=> $stable(out_value));

endmodule

bind acc_micro_core acc_micro_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_clr   (out_clr),
   .beat      (beat),
   .en        (en),
   .pc        (pc),
   .mar       (mar),
   .halted    (halted),
   .out_value (out_value)
);

// File: tb/acc_micro_core_tb.sv
`timescale 1ns/1ps
module acc_micro_core_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic out_clr = 1'b0;
   int   checks = 0;
   int   failures = 0;
   int   cnt = 0;
   bit   done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= 0;
      else        cnt <= cnt + 1;
   end

   // 0: LDA 9, ADD A, SUB B, OUT, HLT; 5+7-15 wraps to FD
   localparam logic [7:0] IMG_MAIN [16] = '{
      8'h09, 8'h1A, 8'h2B, 8'hE0, 8'hF0, 8'h00, 8'h00, 8'h00,
      8'h00, 8'h05, 8'h07, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h00};
   // 1: LDA 9, undefined 5A, ADD A, OUT, HLT; F0+25 wraps to 15
   localparam logic [7:0] IMG_WRAP [16] = '{
      8'h09, 8'h5A, 8'h1A, 8'hE0, 8'hF0, 8'h00, 8'h00, 8'h00,
      8'h00, 8'hF0, 8'h25, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
   // 2: LDA E, JMP 4, HLT, HLT, ADD F, OUT, HLT; 11+22 = 33
   localparam logic [7:0] IMG_JMP [16] = '{
      8'h0E, 8'h34, 8'hF0, 8'hF0, 8'h1F, 8'hE0, 8'hF0, 8'h00,
      8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h11, 8'h22};
   // 3: LDA C, OUT, LDA D, OUT, HLT
   localparam logic [7:0] IMG_LDA [16] = '{
      8'h0C, 8'hE0, 8'h0D, 8'hE0, 8'hF0, 8'h00, 8'h00, 8'h00,
      8'h00, 8'h00, 8'h00, 8'h00, 8'h5A, 8'hA5, 8'h00, 8'h00};

   logic [7:0] outs  [4];
   logic [3:0] addrs [4];

   acc_micro_core #(.ROM_IMAGE(IMG_MAIN)) u_dut (
      .clk(clk), .rst_n(rst_n), .out_clr(out_clr), .out_value(outs[0]), .cur_addr(addrs[0]));
   acc_micro_core #(.ROM_IMAGE(IMG_WRAP), .ALU_STYLE(1)) u_dut_wrap (
      .clk(clk), .rst_n(rst_n), .out_clr(out_clr), .out_value(outs[1]), .cur_addr(addrs[1]));
   acc_micro_core #(.ROM_IMAGE(IMG_JMP)) u_dut_jmp (
      .clk(clk), .rst_n(rst_n), .out_clr(out_clr), .out_value(outs[2]), .cur_addr(addrs[2]));
   acc_micro_core #(.ROM_IMAGE(IMG_LDA), .ALU_STYLE(1)) u_dut_lda (
      .clk(clk), .rst_n(rst_n), .out_clr(out_clr), .out_value(outs[3]), .cur_addr(addrs[3]));

   typedef struct packed {
      logic [1:0] dut;
      logic [7:0] cyc;    // sample after this many edges since reset release
      logic [7:0] outv;
      logic [3:0] addr;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VEC [NV] = '{
      '{2'd0, 8'd0,  8'h00, 4'h0, 4'd10},  // R10 reset state
      '{2'd0, 8'd2,  8'h00, 4'h0, 4'd3},   // R3 pc untouched before beat 3
      '{2'd0, 8'd3,  8'h00, 4'h1, 4'd3},   // R3 step in beat 3
      '{2'd1, 8'd3,  8'h00, 4'h1, 4'd1},   // R1
      '{2'd2, 8'd3,  8'h00, 4'h1, 4'd1},   // R1
      '{2'd2, 8'd10, 8'h00, 4'h4, 4'd8},   // R8 jump taken in beat 4
      '{2'd3, 8'd10, 8'h5A, 4'h2, 4'd4},   // R4 first load then output
      '{2'd0, 8'd15, 8'h00, 4'h3, 4'd1},   // R1
      '{2'd2, 8'd20, 8'h00, 4'h5, 4'd8},   // R8 fetch from target
      '{2'd0, 8'd21, 8'h00, 4'h4, 4'd6},   // R6 output not yet loaded
      '{2'd0, 8'd22, 8'hFD, 4'h4, 4'd5},   // R5 subtract wraps
      '{2'd1, 8'd22, 8'h15, 4'h4, 4'd9},   // R9 undefined opcode, add wraps
      '{2'd2, 8'd22, 8'h33, 4'h6, 4'd8},   // R8 result after jump
      '{2'd3, 8'd22, 8'hA5, 4'h4, 4'd4},   // R4 second load overwrites
      '{2'd0, 8'd27, 8'hFD, 4'h5, 4'd2},   // R2 full program through the bus
      '{2'd1, 8'd27, 8'h15, 4'h5, 4'd7},   // R7
      '{2'd2, 8'd27, 8'h33, 4'h7, 4'd7},   // R7
      '{2'd0, 8'd60, 8'hFD, 4'h5, 4'd7},   // R7 frozen after halt
      '{2'd2, 8'd60, 8'h33, 4'h7, 4'd7}    // R7
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   task automatic wait_cnt(input int c);
      while (cnt != c) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         wait_cnt(int'(VEC[i].cyc));
         chk($sformatf("R%0d out dut%0d cyc%0d", VEC[i].req, VEC[i].dut, VEC[i].cyc),
             int'(outs[VEC[i].dut]), int'(VEC[i].outv));
         chk($sformatf("R%0d addr dut%0d cyc%0d", VEC[i].req, VEC[i].dut, VEC[i].cyc),
             int'(addrs[VEC[i].dut]), int'(VEC[i].addr));
      end

      // R6: clear while halted, R7: program counter still frozen
      out_clr = 1'b1;
      @(negedge clk);
      out_clr = 1'b0;
      chk("R6 clear main", int'(outs[0]), 0);
      chk("R6 clear jmp", int'(outs[2]), 0);
      chk("R7 halted pc after clear", int'(addrs[0]), 5);

      // R10: asynchronous reset in the middle of a run
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      wait_cnt(12);
      #1 rst_n = 1'b0;
      #1;
      chk("R10 async reset addr", int'(addrs[0]), 0);
      chk("R10 async reset lda out", int'(outs[3]), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R6: clear on the same edge as the output load wins
      wait_cnt(21);
      out_clr = 1'b1;
      @(negedge clk);
      out_clr = 1'b0;
      chk("R6 clear beats load main", int'(outs[0]), 0);
      chk("R6 clear beats load lda", int'(outs[3]), 0);
      wait_cnt(30);
      chk("R7 output held after halt", int'(outs[0]), 0);
      chk("R7 pc held after halt", int'(addrs[0]), 5);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

endmodule